// File: doc/BRIEF.md
# Linear Frequency Sweep Generator

This block produces a square wave whose frequency moves in a straight line over time. A typical use is ramping the step rate of a stepper motor drive up to speed and back down. Two accumulators work in series. A frequency register (the phase increment) is adjusted by a programmable sweep rate on every clock. A 32-bit phase accumulator then adds that increment on every clock. The square wave is the top bit of the phase, so the output frequency is increment × fclk / 2^32. The top bits of the phase are also exported, so an external table can shape an arbitrary waveform.

A one-cycle start command loads the start frequency word and clears the phase. At the same edge it captures the end frequency word and the sweep direction. The block then steps towards the end word. When a step would reach or cross the end word, or leave the 32-bit unsigned range, the frequency register is clamped to the end word. A one-cycle done pulse marks that edge, and the tone continues at the end frequency.

The controller has three states:
- IDLE: after reset; no stepping.
- SWEEP: stepping once per clock.
- HOLD: clamped at the end word.

Its transitions are:
- START: IDLE, SWEEP or HOLD to SWEEP, on the start command.
- ARRIVE: SWEEP to HOLD, when the clamp condition is met.
- STAY: remain in the current state when neither applies.

Top module: `chirp_sweep_gen`

## Requirements
- R1: While synchronous reset is high, at the following edge the frequency word, the phase (so the square wave and phase bits) and the done flag all become zero, and the block goes to IDLE.
- R2: A start command sampled at an edge sets the frequency word to the start word and the phase to zero at that edge, from any state.
- R3: Outside reset and start, the phase becomes (phase + frequency word) mod 2^32 at every edge. The square wave is phase bit 31, and the phase output is phase bits 31 down to 24.
- R4: In SWEEP with the captured direction up (direction input 0 at start), each edge adds the sweep rate to the frequency word unless the clamp of R6 applies.
- R5: In SWEEP with the captured direction down (direction input 1 at start), each edge subtracts the sweep rate from the frequency word unless the clamp of R7 applies.
- R6: Sweeping up, if word + rate is at least the captured end word, or exceeds 2^32 − 1, the frequency word becomes the end word and the block enters HOLD.
- R7: Sweeping down, if word − rate is at most the captured end word, or is below zero, the frequency word becomes the end word and the block enters HOLD.
- R8: The done flag is high for exactly the one cycle after the clamping edge. In HOLD the frequency word stays constant.
- R9: The direction and end word are captured at start. Changing those inputs during a sweep has no effect on it.
- R10: A start command during SWEEP or HOLD restarts the sweep from the new start word with the phase cleared.
- R11: With a sweep rate of zero and the end word not reached, the frequency word stays at the start word and no done pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_i | input | 32 | Sweep rate added to or subtracted from the frequency word each clock |
| f_start_i | input | 32 | Start frequency word, loaded on start |
| f_end_i | input | 32 | End frequency word, captured on start |
| go_i | input | 1 | Start command, one cycle |
| dir_down_i | input | 1 | Direction, captured on start: 0 sweeps up, 1 sweeps down |
| sq_o | output | 1 | Square wave (phase MSB) |
| phase_top_o | output | 8 | Top phase bits for an external waveform table |
| freq_o | output | 32 | Current frequency word |
| done_o | output | 1 | One-cycle pulse when the end word is reached |

## Verification
The embedded properties are checked on every cycle. They cover:
- the phase step relation and the start load;
- an up sweep never decreasing the word, and a down sweep never increasing it;
- the clamp landing exactly on the captured end word;
- the single-cycle done pulse and HOLD stability.

The bench's scenarios are needed for the rest:
- the exact number of edges to arrival;
- saturation at both ends of the unsigned range;
- ignoring direction and end-word changes mid-sweep;
- restart during a sweep;
- the zero-rate case that never finishes;
- phase wraparound.

A cycle-accurate scoreboard compares every cycle against a reference model.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
    localparam int unsigned CHIRP_FW  = 32;
    localparam int unsigned CHIRP_PHO = 8;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SWEEP = 2'd1,
        S_HOLD  = 2'd2
    } sweep_state_e;
endpackage

// File: rtl/chirp_ctrl.sv
module chirp_ctrl
    import chirp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    input  logic hit_i,
    output logic load_o,
    output logic step_o,
    output logic done_o
);
    sweep_state_e state_q, state_d;
    logic         done_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            done_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_o  <= done_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        load_o  = go_i;
        step_o  = 1'b0;
        done_d  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (go_i) state_d = S_SWEEP;            // START
            end
            S_SWEEP: begin
                if (go_i) begin
                    state_d = S_SWEEP;                  // START (restart)
                end else begin
                    step_o = 1'b1;
                    if (hit_i) begin
                        state_d = S_HOLD;               // ARRIVE
                        done_d  = 1'b1;
                    end
                end
            end
            S_HOLD: begin
                if (go_i) state_d = S_SWEEP;            // START
            end
            default: state_d = S_IDLE;
        endcase
    end

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: HOLD persists until a new start
    p_hold_stay_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_HOLD && !go_i) |=> state_q == S_HOLD);

    // R2: start always enters SWEEP
    p_start_sweep_r2: assert property (@(posedge clk) disable iff (rst)
        go_i |=> state_q == S_SWEEP);
endmodule

// File: rtl/chirp_rate_acc.sv
module chirp_rate_acc #(
    parameter int unsigned FW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [FW-1:0] rate_i,
    input  logic [FW-1:0] f_start_i,
    input  logic [FW-1:0] f_end_i,
    input  logic          dir_down_i,
    output logic [FW-1:0] inc_o,
    output logic          hit_o
);
    localparam int unsigned EW = FW + 1;

    logic [FW-1:0] inc_q, end_q;
    logic          down_q;
    logic [EW-1:0] sum_w, diff_w;
    logic [FW-1:0] next_w;

    assign sum_w  = {1'b0, inc_q} + {1'b0, rate_i};
    assign diff_w = {1'b0, inc_q} - {1'b0, rate_i};

    always_comb begin
        if (down_q) begin
            next_w = diff_w[FW-1:0];
            hit_o  = diff_w[FW] | (diff_w[FW-1:0] <= end_q);
        end else begin
            next_w = sum_w[FW-1:0];
            hit_o  = sum_w[FW] | (sum_w[FW-1:0] >= end_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inc_q  <= '0;
            end_q  <= '0;
            down_q <= 1'b0;
        end else if (load_i) begin
            inc_q  <= f_start_i;
            end_q  <= f_end_i;
            down_q <= dir_down_i;
        end else if (step_i) begin
            inc_q  <= hit_o ? end_q : next_w;
        end
    end

    assign inc_o = inc_q;

    // R4: an up step never lowers the word
    p_up_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (step_i && !down_q && !hit_o) |=> inc_q >= $past(inc_q));

    // R5: a down step never raises the word
    p_down_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (step_i && down_q && !hit_o) |=> inc_q <= $past(inc_q));

    // R6 / R7: clamping lands on the captured end word
    p_clamp_end_r6: assert property (@(posedge clk) disable iff (rst)
        (step_i && hit_o) |=> inc_q == $past(end_q));

    // R8: word frozen when neither loading nor stepping
    p_idle_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !load_i) |=> $stable(inc_q));
endmodule

// File: rtl/chirp_phase_acc.sv
module chirp_phase_acc #(
    parameter int unsigned FW  = 32,
    parameter int unsigned PHO = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_i,
    input  logic [FW-1:0]  inc_i,
    output logic           sq_o,
    output logic [PHO-1:0] top_o
);
    logic [FW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) phase_q <= '0;
        else              phase_q <= phase_q + inc_i;
    end

    assign sq_o  = phase_q[FW-1];
    assign top_o = phase_q[FW-1 -: PHO];

    // R3: phase advances by the increment, modulo 2^FW
    p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> phase_q == $past(phase_q) + $past(inc_i));
endmodule

// File: rtl/chirp_sweep_gen.sv
module chirp_sweep_gen
    import chirp_pkg::*;
#(
    parameter int unsigned FW  = CHIRP_FW,
    parameter int unsigned PHO = CHIRP_PHO
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [FW-1:0]  rate_i,
    input  logic [FW-1:0]  f_start_i,
    input  logic [FW-1:0]  f_end_i,
    input  logic           go_i,
    input  logic           dir_down_i,
    output logic           sq_o,
    output logic [PHO-1:0] phase_top_o,
    output logic [FW-1:0]  freq_o,
    output logic           done_o
);
    logic load_w, step_w, hit_w;

    chirp_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .go_i   (go_i),
        .hit_i  (hit_w),
        .load_o (load_w),
        .step_o (step_w),
        .done_o (done_o)
    );

    chirp_rate_acc #(.FW(FW)) u_rate (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_w),
        .step_i     (step_w),
        .rate_i     (rate_i),
        .f_start_i  (f_start_i),
        .f_end_i    (f_end_i),
        .dir_down_i (dir_down_i),
        .inc_o      (freq_o),
        .hit_o      (hit_w)
    );

    chirp_phase_acc #(.FW(FW), .PHO(PHO)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .clr_i (load_w),
        .inc_i (freq_o),
        .sq_o  (sq_o),
        .top_o (phase_top_o)
    );

    // R2: start loads the start word and zeroes the phase
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        go_i |=> (freq_o == $past(f_start_i)) && (phase_top_o == '0) && !sq_o);

    // R1: reset leaves everything at zero
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (freq_o == '0) && !sq_o && !done_o && (phase_top_o == '0));
endmodule

// File: tb/chirp_sweep_gen_tb.sv
module chirp_sweep_gen_tb;
    localparam int PHO = 8;

    typedef struct packed {
        logic [31:0] inc;
        logic [31:0] ph;
        logic        done;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rate_i = '0, f_start_i = '0, f_end_i = '0;
    logic        go_i = 1'b0, dir_down_i = 1'b0;
    logic        sq_o, done_o;
    logic [PHO-1:0] phase_top_o;
    logic [31:0] freq_o;

    int checks = 0, failures = 0;
    string cur_req = "R1";
    exp_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    chirp_sweep_gen u_dut (
        .clk(clk), .rst(rst), .rate_i(rate_i), .f_start_i(f_start_i),
        .f_end_i(f_end_i), .go_i(go_i), .dir_down_i(dir_down_i),
        .sq_o(sq_o), .phase_top_o(phase_top_o), .freq_o(freq_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model: pushes one expected item per edge
    longint m_inc = 0, m_ph = 0, m_end = 0;
    bit     m_down = 0, m_done = 0;
    int     m_state = 0;     // 0 idle, 1 sweep, 2 hold
    always @(posedge clk) begin
        longint nxt;
        exp_t e;
        if (rst) begin
            m_inc = 0; m_ph = 0; m_done = 0; m_state = 0; m_end = 0; m_down = 0;
        end else begin
            m_ph   = go_i ? 0 : ((m_ph + m_inc) & 64'hFFFF_FFFF);
            m_done = 0;
            if (go_i) begin
                m_inc = longint'(f_start_i); m_end = longint'(f_end_i);
                m_down = dir_down_i; m_state = 1;
            end else if (m_state == 1) begin
                nxt = m_down ? m_inc - longint'(rate_i) : m_inc + longint'(rate_i);
                if ((!m_down && nxt >= m_end) || (m_down && nxt <= m_end)) begin
                    m_inc = m_end; m_done = 1; m_state = 2;
                end else begin
                    m_inc = nxt;
                end
            end
        end
        e.inc = m_inc[31:0]; e.ph = m_ph[31:0]; e.done = m_done;
        sb_q.push_back(e);
    end

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check(freq_o == e.inc, {cur_req, " freq"}, freq_o, e.inc);
            check(phase_top_o == e.ph[31:24], "R3 phase_top", phase_top_o, e.ph[31:24]);
            check(sq_o == e.ph[31], "R3 square", sq_o, e.ph[31]);
            check(done_o == e.done, {cur_req, " done"}, done_o, e.done);
        end
    end

    task automatic start(input logic [31:0] fs, input logic [31:0] fe,
                         input logic [31:0] rt, input logic dn);
        @(negedge clk);
        f_start_i = fs; f_end_i = fe; rate_i = rt; dir_down_i = dn; go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
    endtask

    task automatic wait_done(output int cnt);
        cnt = 1;
        while (!done_o && cnt < 1000) begin
            @(negedge clk);
            if (!done_o) cnt++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(freq_o == 0 && !sq_o && !done_o && phase_top_o == 0, "R1 reset", freq_o, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R4, R6, R8: up sweep 100 -> 1000 by 100 arrives after 9 edges
        cur_req = "R4";
        start(100, 1000, 100, 1'b0);
        wait_done(n);
        check(n == 9, "R6 edges to arrival", n, 9);
        check(freq_o == 1000, "R6 clamp value", freq_o, 1000);
        cur_req = "R8";
        repeat (5) @(negedge clk);
        check(freq_o == 1000 && !done_o, "R8 hold", freq_o, 1000);

        // R5, R7: down sweep 5000 -> 1000 by 700 arrives after 6 edges
        cur_req = "R5";
        start(5000, 1000, 700, 1'b1);
        wait_done(n);
        check(n == 6, "R7 edges to arrival", n, 6);
        check(freq_o == 1000, "R7 clamp value", freq_o, 1000);

        // R6: up sweep past the top of the range saturates at the end word
        cur_req = "R6";
        start(32'hFFFF_FF00, 32'hFFFF_FFFF, 32'h80, 1'b0);
        wait_done(n);
        check(n == 2, "R6 wrap edges", n, 2);
        check(freq_o == 32'hFFFF_FFFF, "R6 wrap clamp", freq_o, 32'hFFFF_FFFF);

        // R7: down sweep below zero clamps
        cur_req = "R7";
        start(32'h50, 32'h10, 32'h60, 1'b1);
        wait_done(n);
        check(n == 1, "R7 borrow edges", n, 1);
        check(freq_o == 32'h10, "R7 borrow clamp", freq_o, 32'h10);

        // R9: direction and end changes mid-sweep ignored
        cur_req = "R9";
        start(0, 10000, 10, 1'b0);
        repeat (2) @(negedge clk);
        dir_down_i = 1'b1; f_end_i = 32'd5;
        repeat (3) @(negedge clk);
        check(freq_o == 50 && !done_o, "R9 captured direction", freq_o, 50);

        // R10: restart during a sweep
        cur_req = "R10";
        start(7, 10000, 1, 1'b0);
        check(freq_o == 7 && phase_top_o == 0 && !sq_o, "R10 restart", freq_o, 7);
        // R2: load value after the start edge
        check(freq_o == 7, "R2 start load", freq_o, 7);

        // R11: zero rate never finishes
        cur_req = "R11";
        start(300, 900, 0, 1'b0);
        repeat (20) @(negedge clk);
        check(freq_o == 300 && !done_o, "R11 zero rate", freq_o, 300);

        // R3: quarter-turn increment wraps the phase
        cur_req = "R3";
        start(32'h4000_0000, 32'hFFFF_FFFF, 0, 1'b0);
        repeat (2) @(negedge clk);
        check(sq_o == 1'b1 && phase_top_o == 8'h80, "R3 half turn", phase_top_o, 8'h80);
        repeat (2) @(negedge clk);
        check(sq_o == 1'b0 && phase_top_o == 8'h00, "R3 wrap", phase_top_o, 8'h00);

        // R1: reset mid-run
        cur_req = "R1";
        rst = 1'b1;
        @(negedge clk);
        check(freq_o == 0 && phase_top_o == 0 && !done_o, "R1 reset again", freq_o, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule